// File: doc/BRIEF.md
# Delayed Transaction Retry Controller

This block sits on the target side of a parallel bus and turns slow accesses into delayed transactions. When an access arrives that cannot finish at once, the block stores its command, address, byte enables and write data in a free record and ends the attempt with a retry (stop without ready). It then runs the stored access on a request/acknowledge back-end port. When the initiator repeats the identical request after the back-end access has finished, the block completes it with one data phase and disconnects.

The number of records is a parameter. While every record is in use, a new request that matches none of them is retried and not stored. Such a request can only be accepted after a record has been handed back to its initiator, or dropped by the discard timer. A completed record that no matching retry collects within a parameterised number of clocks is freed.

Top module: `dtr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trdy_o`, `stop_o` and `be_req_o` are low and every record is free.
- R2: An attempt is a cycle in which `frame_i` and `irdy_i` are both high. The block answers it in the next cycle with `stop_o` high. A cycle with `frame_i` high and `irdy_i` low gets no answer.
- R3: An attempt that matches no record, while a record is free, is stored in the free record with the lowest index and answered with `stop_o` high and `trdy_o` low.
- R4: An attempt matches a record when its command, address and byte enables equal the stored ones. When command bit 0 is 1 (write), the write data must also be equal. For reads, the write data is not compared.
- R5: A stored record is issued on the back-end port in the cycle after the clock edge that follows its storage, if the port is idle. Pending records are issued lowest index first, and only one access is in flight at a time. `be_req_o`, `be_we_o` (command bit 0), `be_addr_o`, `be_be_o` and `be_wdata_o` stay stable until `be_ack_i` is sampled high.
- R6: A matching attempt that arrives before the back-end access of its record has been acknowledged is retried again (stop only), and the record is kept.
- R7: A matching attempt that arrives after the acknowledge is answered with `trdy_o` and `stop_o` high together, and `rdata_o` carries the back-end read data. The record is then freed. `rdata_o` is zero in every cycle in which `trdy_o` is low.
- R8: While all records are occupied, a non-matching attempt is retried and not stored. No back-end access is made for it.
- R9: A completed record is freed DISCARD_CYCLES clocks after the acknowledge edge if no matching attempt has collected it. A matching attempt sampled on the last of those edges still completes.
- R10: `trdy_o` is never high unless `stop_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Initiator has a transaction in progress |
| irdy_i | input | 1 | Initiator ready; with frame_i marks an attempt |
| cmd_i | input | CW | Bus command; bit 0 set means write |
| addr_i | input | AW | Address |
| be_i | input | BW | Byte enables |
| wdata_i | input | DW | Write data |
| trdy_o | output | 1 | Target ready: data phase completes |
| stop_o | output | 1 | Target stop: retry or disconnect |
| rdata_o | output | DW | Read data on completion |
| be_req_o | output | 1 | Back-end access request |
| be_we_o | output | 1 | Back-end write |
| be_addr_o | output | AW | Back-end address |
| be_be_o | output | BW | Back-end byte enables |
| be_wdata_o | output | DW | Back-end write data |
| be_ack_i | input | 1 | Back-end access done |
| be_rdata_i | input | DW | Back-end read data, valid with be_ack_i |

## Verification
Every front-end result is registered, so the answer to an attempt is due exactly one clock after the edge that samples it. A stored record raises `be_req_o` one edge later still, and its acknowledge turns it collectable from the edge that samples `be_ack_i`. The discard window closes DISCARD_CYCLES edges after that acknowledge. The bench drives inputs on the falling edge and keeps a behavioural model updated on the rising edge. It compares every output on the next falling edge, so each result is checked in the cycle it becomes due. The directed checks on the discard boundary are placed by counting falling edges from the one on which the acknowledge is seen.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_BUSY = 2'd2,
    SLOT_DONE = 2'd3
  } slot_st_e;
endpackage

// File: rtl/dtr_slot.sv
module dtr_slot
  import dtr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int BW = 4,
  parameter int DISCARD_CYCLES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          att_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rec_i,
  input  logic          issue_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  output slot_st_e      state_o,
  output logic          match_o,
  output logic          take_o,
  output logic [CW-1:0] cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CNTW = $clog2(DISCARD_CYCLES + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(DISCARD_CYCLES - 1);

  slot_st_e        st_q;
  logic [CW-1:0]   cmd_q;
  logic [AW-1:0]   addr_q;
  logic [BW-1:0]   be_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic [CNTW-1:0] cnt_q;

  // write data only counts for writes
  always_comb begin
    match_o = (st_q != SLOT_FREE) && (cmd_q == cmd_i) && (addr_q == addr_i) &&
              (be_q == be_i) && (!cmd_q[0] || (wdata_q == wdata_i));
    take_o  = att_i && match_o && (st_q == SLOT_DONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SLOT_FREE;
      cmd_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (st_q)
        SLOT_FREE: if (rec_i) begin
          st_q    <= SLOT_PEND;
          cmd_q   <= cmd_i;
          addr_q  <= addr_i;
          be_q    <= be_i;
          wdata_q <= wdata_i;
        end
        SLOT_PEND: if (issue_i) st_q <= SLOT_BUSY;
        SLOT_BUSY: if (done_i) begin
          st_q    <= SLOT_DONE;
          rdata_q <= rdata_i;
          cnt_q   <= '0;
        end
        SLOT_DONE: begin
          if (take_o || (cnt_q == CNT_LAST)) st_q <= SLOT_FREE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SLOT_FREE;
      endcase
    end
  end

  assign state_o = st_q;
  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign be_o    = be_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  // R3
  rec_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |-> (st_q == SLOT_FREE));
  // R7
  take_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (st_q == SLOT_FREE));
  // R6
  early_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_i && match_o && (st_q inside {SLOT_PEND, SLOT_BUSY})) |=> (st_q != SLOT_FREE));
  // R5
  issue_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (st_q == SLOT_PEND));
endmodule

// File: rtl/dtr_backend.sv
module dtr_backend #(
  parameter int SLOTS = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int BW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] pend_i,
  input  logic [CW-1:0]    cmd_i   [SLOTS],
  input  logic [AW-1:0]    addr_i  [SLOTS],
  input  logic [BW-1:0]    be_i    [SLOTS],
  input  logic [DW-1:0]    wdata_i [SLOTS],
  input  logic             be_ack_i,
  output logic [SLOTS-1:0] issue_o,
  output logic [SLOTS-1:0] done_o,
  output logic             be_req_o,
  output logic             be_we_o,
  output logic [AW-1:0]    be_addr_o,
  output logic [BW-1:0]    be_be_o,
  output logic [DW-1:0]    be_wdata_o
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic          busy_q;
  logic [IW-1:0] sel_q;
  logic [IW-1:0] pick;
  logic          any;

  // lowest index wins
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any  = 1'b1;
        pick = IW'(i);
      end
    end
  end

  assign issue_o = (!busy_q && any) ? (SLOTS'(1) << pick) : '0;
  assign done_o  = (busy_q && be_ack_i) ? (SLOTS'(1) << sel_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
    end else if (busy_q) begin
      if (be_ack_i) busy_q <= 1'b0;
    end else if (any) begin
      busy_q <= 1'b1;
      sel_q  <= pick;
    end
  end

  assign be_req_o   = busy_q;
  assign be_we_o    = cmd_i[sel_q][0];
  assign be_addr_o  = addr_i[sel_q];
  assign be_be_o    = be_i[sel_q];
  assign be_wdata_o = wdata_i[sel_q];

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_o && !be_ack_i) |=> (be_req_o && $stable(be_addr_o) && $stable(be_wdata_o) &&
                                 $stable(be_be_o) && $stable(be_we_o)));
  // R5
  one_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_o));
  // R5
  no_issue_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |-> (issue_o == '0));
endmodule

// File: rtl/dtr_resp.sv
module dtr_resp #(
  parameter int SLOTS = 2,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             att_i,
  input  logic [SLOTS-1:0] match_i,
  input  logic [SLOTS-1:0] take_i,
  input  logic [SLOTS-1:0] free_i,
  input  logic [DW-1:0]    rdata_i [SLOTS],
  output logic [SLOTS-1:0] rec_o,
  output logic             trdy_o,
  output logic             stop_o,
  output logic [DW-1:0]    rdata_o
);
  logic          hit;
  logic          found;
  logic [DW-1:0] rsel;
  logic          trdy_q;
  logic          stop_q;
  logic [DW-1:0] rdata_q;

  assign hit = |match_i;

  always_comb begin
    rec_o = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (att_i && !hit && free_i[i] && !found) begin
        rec_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (take_i[i]) rsel = rsel | rdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      stop_q  <= att_i;
      trdy_q  <= |take_i;
      rdata_q <= rsel;
    end
  end

  assign trdy_o  = trdy_q;
  assign stop_o  = stop_q;
  assign rdata_o = rdata_q;

  // R3
  rec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rec_o));
  // R8
  full_no_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i == '0) |-> (rec_o == '0));
endmodule

// File: rtl/dtr_ctrl.sv
module dtr_ctrl
  import dtr_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int BW = DW / 8,
  parameter int DISCARD_CYCLES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          irdy_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic          trdy_o,
  output logic          stop_o,
  output logic [DW-1:0] rdata_o,
  output logic          be_req_o,
  output logic          be_we_o,
  output logic [AW-1:0] be_addr_o,
  output logic [BW-1:0] be_be_o,
  output logic [DW-1:0] be_wdata_o,
  input  logic          be_ack_i,
  input  logic [DW-1:0] be_rdata_i
);
  logic             att;
  slot_st_e         st       [SLOTS];
  logic [CW-1:0]    s_cmd    [SLOTS];
  logic [AW-1:0]    s_addr   [SLOTS];
  logic [BW-1:0]    s_be     [SLOTS];
  logic [DW-1:0]    s_wdata  [SLOTS];
  logic [DW-1:0]    s_rdata  [SLOTS];
  logic [SLOTS-1:0] match_v, take_v, free_v, pend_v, busy_v;
  logic [SLOTS-1:0] rec_v, issue_v, done_v;

  assign att = frame_i && irdy_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    dtr_slot #(
      .AW(AW), .DW(DW), .CW(CW), .BW(BW), .DISCARD_CYCLES(DISCARD_CYCLES)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .att_i   (att),
      .cmd_i   (cmd_i),
      .addr_i  (addr_i),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .rec_i   (rec_v[g]),
      .issue_i (issue_v[g]),
      .done_i  (done_v[g]),
      .rdata_i (be_rdata_i),
      .state_o (st[g]),
      .match_o (match_v[g]),
      .take_o  (take_v[g]),
      .cmd_o   (s_cmd[g]),
      .addr_o  (s_addr[g]),
      .be_o    (s_be[g]),
      .wdata_o (s_wdata[g]),
      .rdata_o (s_rdata[g])
    );
    assign free_v[g] = (st[g] == SLOT_FREE);
    assign pend_v[g] = (st[g] == SLOT_PEND);
    assign busy_v[g] = (st[g] == SLOT_BUSY);
  end

  dtr_backend #(
    .SLOTS(SLOTS), .AW(AW), .DW(DW), .CW(CW), .BW(BW)
  ) u_backend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend_v),
    .cmd_i      (s_cmd),
    .addr_i     (s_addr),
    .be_i       (s_be),
    .wdata_i    (s_wdata),
    .be_ack_i   (be_ack_i),
    .issue_o    (issue_v),
    .done_o     (done_v),
    .be_req_o   (be_req_o),
    .be_we_o    (be_we_o),
    .be_addr_o  (be_addr_o),
    .be_be_o    (be_be_o),
    .be_wdata_o (be_wdata_o)
  );

  dtr_resp #(
    .SLOTS(SLOTS), .DW(DW)
  ) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .att_i   (att),
    .match_i (match_v),
    .take_i  (take_v),
    .free_i  (free_v),
    .rdata_i (s_rdata),
    .rec_o   (rec_v),
    .trdy_o  (trdy_o),
    .stop_o  (stop_o),
    .rdata_o (rdata_o)
  );

  // R10
  trdy_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> stop_o);
  // R5
  one_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_v) <= 1);
  // R5
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o == (busy_v != '0));
  // R7
  rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_o |-> (rdata_o == '0));
endmodule

// File: tb/dtr_ctrl_test.sv
`timescale 1ns/1ps
module dtr_ctrl_test;
  localparam int NS  = 2;
  localparam int LIM = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0, irdy = 1'b0;
  logic [3:0]  cmd = '0, be = '0;
  logic [31:0] addr = '0, wdata = '0;
  logic        trdy_o, stop_o, be_req_o, be_we_o, be_ack_i;
  logic [31:0] rdata_o, be_addr_o, be_wdata_o, be_rdata_i;
  logic [3:0]  be_be_o;

  int vecs = 0, fails = 0, lat = 4, wcnt = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  dtr_ctrl #(.SLOTS(NS), .DISCARD_CYCLES(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .irdy_i(irdy), .cmd_i(cmd),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .trdy_o(trdy_o), .stop_o(stop_o),
    .rdata_o(rdata_o), .be_req_o(be_req_o), .be_we_o(be_we_o), .be_addr_o(be_addr_o),
    .be_be_o(be_be_o), .be_wdata_o(be_wdata_o), .be_ack_i(be_ack_i), .be_rdata_i(be_rdata_i)
  );

  function automatic logic [31:0] rd_fn(logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  // back-end responder
  assign be_rdata_i = rd_fn(be_addr_o);
  assign be_ack_i   = be_req_o && (wcnt >= lat);
  always @(posedge clk) wcnt <= (be_req_o && !be_ack_i) ? wcnt + 1 : 0;

  // behavioural reference: 0 free, 1 waiting, 2 in flight, 3 done
  int          m_st[NS], m_cnt[NS], m_sel;
  logic [3:0]  m_cmd[NS], m_be[NS];
  logic [31:0] m_addr[NS], m_wd[NS], m_rd[NS];
  bit          m_busy, e_stop, e_trdy;
  logic [31:0] e_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
      m_busy = 0; m_sel = 0; e_stop = 0; e_trdy = 0; e_rdata = '0;
    end else begin : step
      int hit, fr, pk;
      bit att, ack;
      hit = -1; fr = -1; pk = -1;
      att = frame && irdy;
      ack = be_ack_i && m_busy;
      for (int i = 0; i < NS; i++) begin
        if (att && m_st[i] != 0 && m_cmd[i] == cmd && m_addr[i] == addr && m_be[i] == be &&
            (!m_cmd[i][0] || m_wd[i] == wdata)) hit = i;
        if (m_st[i] == 0 && fr < 0) fr = i;
        if (m_st[i] == 1 && pk < 0) pk = i;
      end
      e_stop  = att;
      e_trdy  = (hit >= 0) && (m_st[hit] == 3);
      e_rdata = e_trdy ? m_rd[hit] : '0;
      for (int i = 0; i < NS; i++) begin
        if (m_st[i] == 3) begin
          if ((e_trdy && hit == i) || m_cnt[i] == LIM - 1) m_st[i] = 0;
          else m_cnt[i]++;
        end
      end
      if (ack) begin
        m_st[m_sel] = 3; m_cnt[m_sel] = 0; m_rd[m_sel] = rd_fn(m_addr[m_sel]); m_busy = 0;
      end else if (!m_busy && pk >= 0) begin
        m_st[pk] = 2; m_sel = pk; m_busy = 1;
      end
      if (att && hit < 0 && fr >= 0) begin
        m_st[fr] = 1; m_cmd[fr] = cmd; m_addr[fr] = addr; m_be[fr] = be; m_wd[fr] = wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R2 stop_o", stop_o, e_stop);
      chk("R7 trdy_o", trdy_o, e_trdy);
      chk("R7 rdata_o", rdata_o, e_rdata);
      chk("R10 trdy without stop", trdy_o & ~stop_o, 0);
      chk("R5 be_req_o", be_req_o, m_busy);
      if (m_busy) begin
        chk("R5 be_addr_o", be_addr_o, m_addr[m_sel]);
        chk("R5 be_we_o", be_we_o, m_cmd[m_sel][0]);
        chk("R5 be_be_o", be_be_o, m_be[m_sel]);
        chk("R5 be_wdata_o", be_wdata_o, m_wd[m_sel]);
      end
    end
  end

  task automatic report();
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  task automatic attempt(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                         input logic [31:0] d, output bit t, output bit s, output logic [31:0] rd);
    @(negedge clk);
    frame = 1; irdy = 1; cmd = c; addr = a; be = b; wdata = d;
    @(negedge clk);
    frame = 0; irdy = 0;
    t = trdy_o; s = stop_o; rd = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!be_ack_i) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    bit t, s;
    logic [31:0] rd;
    idle(3);
    // R1 during reset
    chk("R1 stop in reset", stop_o, 0);
    chk("R1 trdy in reset", trdy_o, 0);
    chk("R1 req in reset", be_req_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req after reset", be_req_o, 0);

    // R3 R6 R7 read path
    lat = 4;
    attempt(4'h6, 32'h100, 4'hF, 32'h0, t, s, rd);
    chk("R3 first attempt retried stop", s, 1); chk("R3 first attempt no trdy", t, 0);
    attempt(4'h6, 32'h100, 4'hF, 32'h0, t, s, rd);
    chk("R6 early retry stop", s, 1); chk("R6 early retry no trdy", t, 0);
    wait_done();
    attempt(4'h6, 32'h100, 4'hF, 32'h0, t, s, rd);
    chk("R7 completion trdy", t, 1); chk("R7 completion stop", s, 1);
    chk("R7 completion data", rd, rd_fn(32'h100));
    attempt(4'h6, 32'h100, 4'hF, 32'h0, t, s, rd);
    chk("R7 record freed, new record", t, 0);
    idle(40);

    // R2 frame without irdy
    @(negedge clk); frame = 1; irdy = 0; addr = 32'h180;
    @(negedge clk); frame = 0;
    chk("R2 no answer without irdy", stop_o, 0);
    chk("R2 no request without irdy", be_req_o, 0);

    // R4 write data compare, read ignores it
    attempt(4'h7, 32'h200, 4'h3, 32'h1111, t, s, rd);
    chk("R4 write recorded", t, 0);
    wait_done();
    attempt(4'h7, 32'h200, 4'h3, 32'h2222, t, s, rd);
    chk("R4 write data differs", t, 0);
    attempt(4'h7, 32'h200, 4'h3, 32'h1111, t, s, rd);
    chk("R4 write data equal", t, 1);
    attempt(4'h6, 32'h300, 4'hC, 32'hAAAA, t, s, rd);
    chk("R4 read recorded", t, 0);
    wait_done();
    wait_done();
    attempt(4'h6, 32'h300, 4'hC, 32'hBBBB, t, s, rd);
    chk("R4 read ignores wdata", t, 1);
    chk("R4 read data", rd, rd_fn(32'h300));
    attempt(4'h6, 32'h300, 4'h3, 32'hBBBB, t, s, rd);
    chk("R4 byte enables differ", t, 0);
    idle(40);

    // R8 full records
    lat = 6;
    attempt(4'h6, 32'h400, 4'hF, 32'h0, t, s, rd);
    attempt(4'h6, 32'h500, 4'hF, 32'h0, t, s, rd);
    attempt(4'h6, 32'h600, 4'hF, 32'h0, t, s, rd);
    chk("R8 full retry stop", s, 1); chk("R8 full retry no trdy", t, 0);
    wait_done();
    wait_done();
    attempt(4'h6, 32'h600, 4'hF, 32'h0, t, s, rd);
    chk("R8 still not recorded", t, 0);
    attempt(4'h6, 32'h400, 4'hF, 32'h0, t, s, rd);
    chk("R8 first record completes", t, 1);
    attempt(4'h6, 32'h500, 4'hF, 32'h0, t, s, rd);
    chk("R8 second record completes", t, 1);
    attempt(4'h6, 32'h600, 4'hF, 32'h0, t, s, rd);
    chk("R8 turned-away now recorded", t, 0);
    wait_done();
    attempt(4'h6, 32'h600, 4'hF, 32'h0, t, s, rd);
    chk("R8 turned-away completes", t, 1);
    chk("R8 turned-away data", rd, rd_fn(32'h600));
    idle(40);

    // R9 discard boundary
    lat = 2;
    attempt(4'h6, 32'h700, 4'hF, 32'h0, t, s, rd);
    wait_done();
    idle(LIM - 2);
    attempt(4'h6, 32'h700, 4'hF, 32'h0, t, s, rd);
    chk("R9 last cycle still completes", t, 1);
    attempt(4'h6, 32'h800, 4'hF, 32'h0, t, s, rd);
    wait_done();
    idle(LIM - 1);
    attempt(4'h6, 32'h800, 4'hF, 32'h0, t, s, rd);
    chk("R9 discarded record", t, 0);
    idle(40);

    report();
  end
endmodule